// File: doc/BRIEF.md
# Conversion Request Priority Arbiter

This block decides which of sixteen conversion slots a single shared converter handles next. Every slot owns a trigger-source select. A strobe on the chosen source marks the slot as waiting. The arbiter grants one waiting slot at a time, drives a one-cycle start strobe together with the slot number, and then waits for the converter's done pulse before it grants again.

A programmable cutoff splits the slots into two groups. Slots numbered below the cutoff form a fixed-priority group, in which the lowest number wins. The remaining slots share a round-robin wheel. A pointer on the wheel records the last round-robin slot converted, and software can read it. A fixed-priority request never interrupts a running conversion. It takes the next boundary, and the wheel then carries on from its saved pointer. In burst mode the wheel slots no longer watch their own triggers. Instead, one burst trigger releases a set number of consecutive wheel conversions.

The controller is a three-state machine:
- `ST_IDLE` waits for a request. The transition `grant_from_idle` leads to `ST_LAUNCH`.
- `ST_LAUNCH` drives the start strobe for one cycle. The transition `launch_done` always leads to `ST_BUSY`.
- `ST_BUSY` waits for the converter. When done arrives, it takes `chain_grant` back to `ST_LAUNCH` if a request is waiting, or `drain` to `ST_IDLE` if none is.

Top module: `conv_slot_arbiter`

## Requirements
- R1: After reset, `start_o` and `busy_o` are low, every `pending_o` and `overflow_o` bit is 0, and `rr_ptr_o` equals 15.
- R2: Slot s takes its source index from bits [3s+2:3s] of `slot_trig_sel_i`. A one-cycle pulse on that bit of `trig_src_i`, seen at clock edge k, sets `pending_o[s]` after edge k. If the arbiter is idle, `start_o` is high for exactly one cycle after edge k+1, and during that cycle `grant_slot_o` equals s.
- R3: A slot whose number is below `hp_cutoff_i` is high priority. When any high-priority slot is waiting at a grant point, the lowest-numbered such slot is granted.
- R4: When no high-priority slot is waiting, the grant goes to the first waiting round-robin slot after `rr_ptr_o`, searching in a circle. `rr_ptr_o` then takes that slot number.
- R5: While a conversion is outstanding, no new start is issued. The next start follows one cycle after the done pulse.
- R6: A high-priority grant leaves `rr_ptr_o` unchanged, so round-robin order resumes from the slot that was last converted before it.
- R7: When `burst_en_i` is 1, round-robin slots ignore their own triggers. A pulse on source `burst_trig_sel_i` releases `burst_size_i`+1 round-robin conversions of consecutive wheel slots, starting after `rr_ptr_o` and wrapping within the wheel. After those, no further wheel conversions occur.
- R8: A trigger for a slot that is already pending sets `overflow_o` for that slot and does not queue a second conversion. The overflow flag clears when the slot is granted.
- R9: A slot's pending flag clears on the cycle it is granted. A trigger during its conversion sets it again, and the slot is converted again.
- R10: With a cutoff of 16, all slots are served in ascending order and `rr_ptr_o` never moves. With a cutoff of 0, all slots are served in wheel order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_src_i | input | 8 | Trigger-source strobes |
| slot_trig_sel_i | input | 48 | Per-slot source index, 3 bits per slot |
| hp_cutoff_i | input | 5 | Number of high-priority slots (0 to 16) |
| burst_en_i | input | 1 | Burst mode enable |
| burst_size_i | input | 4 | Burst length minus one |
| burst_trig_sel_i | input | 3 | Source index of the burst trigger |
| conv_done_i | input | 1 | Converter done pulse |
| start_o | output | 1 | One-cycle conversion start |
| grant_slot_o | output | 4 | Slot being started |
| busy_o | output | 1 | Arbiter not idle |
| rr_ptr_o | output | 4 | Last round-robin slot converted |
| pending_o | output | 16 | Per-slot pending flags |
| overflow_o | output | 16 | Per-slot lost-trigger flags |

## Verification
A pending flag appears one edge after its trigger. When the arbiter is idle, the start strobe follows one edge later. A chained start appears one cycle after the done pulse. The bench drives inputs on falling edges and reads `pending_o` and `start_o` on the falling edge that matches these latencies. A falling-edge monitor logs every start and flags any start that comes while the converter model still counts. Grant sequences, including those from the random batches, are compared afterwards with an order that a bench function computes from the pending set, the cutoff and the pointer value read before the batch.

// File: rtl/csa_pkg.sv
package csa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_BUSY
    } arb_state_e;
endpackage

// File: rtl/csa_pend_bank.sv
module csa_pend_bank #(
    parameter int N_SLOT = 16,
    parameter int N_TRIG = 8,
    localparam int SLOT_W = $clog2(N_SLOT),
    localparam int TSEL_W = $clog2(N_TRIG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_TRIG-1:0]        trig_src,
    input  logic [N_SLOT*TSEL_W-1:0] sel_flat,
    input  logic [N_SLOT-1:0]        hp_mask,
    input  logic                     burst_en,
    input  logic                     grant_vld,
    input  logic [SLOT_W-1:0]        grant_slot,
    output logic [N_SLOT-1:0]        pending,
    output logic [N_SLOT-1:0]        overflow
);
    for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
        logic [TSEL_W-1:0] sel;
        logic              hit;
        logic              take;

        assign sel  = sel_flat[i*TSEL_W +: TSEL_W];
        // wheel slots listen only to the burst trigger while burst mode is on
        assign hit  = trig_src[sel] && !(burst_en && !hp_mask[i]);
        assign take = grant_vld && (grant_slot == SLOT_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pending[i]  <= 1'b0;
                overflow[i] <= 1'b0;
            end else begin
                if (hit)
                    pending[i] <= 1'b1;
                else if (take)
                    pending[i] <= 1'b0;
                if (take)
                    overflow[i] <= 1'b0;
                else if (hit && pending[i])
                    overflow[i] <= 1'b1;
            end
        end

        AST_OVF_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(overflow[i]) |-> $past(pending[i])); // R8
    end
endmodule

// File: rtl/csa_pick.sv
module csa_pick #(
    parameter int N_SLOT = 16,
    localparam int SLOT_W = $clog2(N_SLOT)
) (
    input  logic [N_SLOT-1:0] hp_req,
    input  logic [N_SLOT-1:0] rr_req,
    input  logic [SLOT_W-1:0] rr_ptr,
    output logic              any_vld,
    output logic              pick_is_hp,
    output logic [SLOT_W-1:0] pick_slot
);
    logic              hp_found;
    logic              rr_found;
    logic [SLOT_W-1:0] hp_idx;
    logic [SLOT_W-1:0] rr_idx;

    // fixed region: lowest index wins, so scan downwards and keep the last hit
    always_comb begin
        hp_found = 1'b0;
        hp_idx   = '0;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (hp_req[i]) begin
                hp_found = 1'b1;
                hp_idx   = SLOT_W'(i);
            end
        end
    end

    // wheel: nearest request after the pointer, scanning far to near
    always_comb begin
        rr_found = 1'b0;
        rr_idx   = '0;
        for (int k = N_SLOT; k >= 1; k--) begin
            int idx;
            idx = (int'(rr_ptr) + k) % N_SLOT;
            if (rr_req[idx]) begin
                rr_found = 1'b1;
                rr_idx   = SLOT_W'(idx);
            end
        end
    end

    assign any_vld    = hp_found || rr_found;
    assign pick_is_hp = hp_found;
    assign pick_slot  = hp_found ? hp_idx : rr_idx;
endmodule

// File: rtl/csa_burst.sv
module csa_burst #(
    parameter int SLOT_W = 4,
    localparam int CNT_W = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en,
    input  logic              burst_hit,
    input  logic [SLOT_W-1:0] burst_size,
    input  logic              rr_grant,
    output logic              burst_live
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (!burst_en)
            left_q <= '0;
        else if (left_q == '0 && burst_hit)
            left_q <= CNT_W'(burst_size) + CNT_W'(1);
        else if (rr_grant && left_q != '0)
            left_q <= left_q - CNT_W'(1);
    end

    assign burst_live = (left_q != '0);

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_en && burst_live && !rr_grant) |=> (left_q == $past(left_q))); // R7
endmodule

// File: rtl/conv_slot_arbiter.sv
module conv_slot_arbiter #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_TRIG  = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CUT_W  = $clog2(NUM_SLOTS + 1),
    localparam int TSEL_W = $clog2(NUM_TRIG)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TRIG-1:0]         trig_src_i,
    input  logic [NUM_SLOTS*TSEL_W-1:0] slot_trig_sel_i,
    input  logic [CUT_W-1:0]            hp_cutoff_i,
    input  logic                        burst_en_i,
    input  logic [SLOT_W-1:0]           burst_size_i,
    input  logic [TSEL_W-1:0]           burst_trig_sel_i,
    input  logic                        conv_done_i,
    output logic                        start_o,
    output logic [SLOT_W-1:0]           grant_slot_o,
    output logic                        busy_o,
    output logic [SLOT_W-1:0]           rr_ptr_o,
    output logic [NUM_SLOTS-1:0]        pending_o,
    output logic [NUM_SLOTS-1:0]        overflow_o
);
    import csa_pkg::*;

    arb_state_e           state_q, state_d;
    logic [NUM_SLOTS-1:0] hp_mask;
    logic [NUM_SLOTS-1:0] hp_req;
    logic [NUM_SLOTS-1:0] rr_req;
    logic                 any_vld;
    logic                 pick_is_hp;
    logic [SLOT_W-1:0]    pick_slot;
    logic                 arb_ok;
    logic                 grant_vld;
    logic                 rr_grant;
    logic                 burst_live;
    logic                 burst_hit;
    logic [SLOT_W-1:0]    slot_q;
    logic                 hp_q;
    logic [SLOT_W-1:0]    ptr_q;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
        assign hp_mask[i] = (CUT_W'(i) < hp_cutoff_i);
    end

    csa_pend_bank #(.N_SLOT(NUM_SLOTS), .N_TRIG(NUM_TRIG)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_src   (trig_src_i),
        .sel_flat   (slot_trig_sel_i),
        .hp_mask    (hp_mask),
        .burst_en   (burst_en_i),
        .grant_vld  (grant_vld),
        .grant_slot (pick_slot),
        .pending    (pending_o),
        .overflow   (overflow_o)
    );

    assign burst_hit = trig_src_i[burst_trig_sel_i];

    csa_burst #(.SLOT_W(SLOT_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_en   (burst_en_i),
        .burst_hit  (burst_hit),
        .burst_size (burst_size_i),
        .rr_grant   (rr_grant),
        .burst_live (burst_live)
    );

    assign hp_req = pending_o & hp_mask;
    assign rr_req = burst_en_i ? (burst_live ? ~hp_mask : '0)
                               : (pending_o & ~hp_mask);

    csa_pick #(.N_SLOT(NUM_SLOTS)) u_pick (
        .hp_req     (hp_req),
        .rr_req     (rr_req),
        .rr_ptr     (ptr_q),
        .any_vld    (any_vld),
        .pick_is_hp (pick_is_hp),
        .pick_slot  (pick_slot)
    );

    // grants happen only between conversions
    assign arb_ok    = (state_q == ST_IDLE) || (state_q == ST_BUSY && conv_done_i);
    assign grant_vld = arb_ok && any_vld;
    assign rr_grant  = grant_vld && !pick_is_hp;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (grant_vld) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_BUSY;
            ST_BUSY:   if (conv_done_i) state_d = grant_vld ? ST_LAUNCH : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            hp_q    <= 1'b0;
            ptr_q   <= SLOT_W'(NUM_SLOTS - 1);
        end else begin
            state_q <= state_d;
            if (grant_vld) begin
                slot_q <= pick_slot;
                hp_q   <= pick_is_hp;
            end
            if (rr_grant)
                ptr_q <= pick_slot;
        end
    end

    always_comb begin
        start_o      = (state_q == ST_LAUNCH);
        busy_o       = (state_q != ST_IDLE);
        grant_slot_o = slot_q;
        rr_ptr_o     = ptr_q;
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R2
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_o && !conv_done_i) |=> !start_o); // R5
    AST_HP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && hp_req != '0) |-> pick_is_hp); // R3
    AST_HP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && hp_q) |-> $stable(rr_ptr_o)); // R6
endmodule

// File: tb/tb_conv_slot_arbiter.sv
module tb_conv_slot_arbiter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  trig = '0;
    logic [47:0] sel_flat = '1;
    logic [4:0]  cutoff = '0;
    logic        burst_en = 1'b0;
    logic [3:0]  burst_size = '0;
    logic [2:0]  burst_sel = '0;
    logic        conv_done = 1'b0;
    logic        start_o, busy_o;
    logic [3:0]  grant_slot_o, rr_ptr_o;
    logic [15:0] pending_o, overflow_o;

    int checks = 0, errors = 0;
    int lat = 3, cnt = 0;
    logic busy_m = 1'b0;
    int glog [0:255];
    int gcnt = 0;
    bit reported = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_slot_arbiter dut (
        .clk(clk), .rst_n(rst_n), .trig_src_i(trig), .slot_trig_sel_i(sel_flat),
        .hp_cutoff_i(cutoff), .burst_en_i(burst_en), .burst_size_i(burst_size),
        .burst_trig_sel_i(burst_sel), .conv_done_i(conv_done), .start_o(start_o),
        .grant_slot_o(grant_slot_o), .busy_o(busy_o), .rr_ptr_o(rr_ptr_o),
        .pending_o(pending_o), .overflow_o(overflow_o)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // converter model: done pulse lat cycles after the start is seen
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (start_o) begin
            cnt    <= lat;
            busy_m <= 1'b1;
        end else if (busy_m) begin
            if (cnt <= 1) begin
                conv_done <= 1'b1;
                busy_m    <= 1'b0;
            end else cnt <= cnt - 1;
        end
    end

    // start monitor
    always @(negedge clk) begin
        if (rst_n && start_o) begin
            if (gcnt < 256) glog[gcnt] = int'(grant_slot_o);
            gcnt++;
            chk(!busy_m, "R5 start during conversion", 1, 0);
        end
    end

    function automatic int exp_next(logic [15:0] p, int ptr, int cut);
        for (int i = 0; i < 16; i++) if (i < cut && p[i]) return i;
        for (int k = 1; k <= 16; k++) begin
            int idx;
            idx = (ptr + k) % 16;
            if (idx >= cut && p[idx]) return idx;
        end
        return -1;
    endfunction

    task automatic set_sel(int s, int v);
        sel_flat[s*3 +: 3] = 3'(v);
    endtask

    task automatic pulse(logic [7:0] m);
        @(negedge clk) trig = m;
        @(negedge clk) trig = '0;
    endtask

    task automatic wait_gcnt(int n);
        for (int i = 0; i < 500 && gcnt < n; i++) @(posedge clk);
    endtask

    task automatic wait_idle();
        int quiet;
        quiet = 0;
        for (int i = 0; i < 3000 && quiet < 4; i++) begin
            @(negedge clk);
            if (!busy_o && !busy_m && pending_o == '0 && trig == '0) quiet++;
            else quiet = 0;
        end
        chk(quiet >= 4, "R5 arbiter drains", quiet, 4);
    endtask

    // compare logged grants with the order computed from the pending set
    task automatic check_order(logic [15:0] p, int ptr0, int cut, string tag);
        int ptr, idx, s;
        ptr = ptr0; idx = 0;
        while (p != '0) begin
            s = exp_next(p, ptr, cut);
            if (s < cut) chk(glog[idx] == s, {tag, " R3 order"}, glog[idx], s);
            else         chk(glog[idx] == s, {tag, " R4 order"}, glog[idx], s);
            if (s >= cut) ptr = s;
            p[s] = 1'b0;
            idx++;
        end
        chk(gcnt == idx, {tag, " R8 grant count"}, gcnt, idx);
        chk(int'(rr_ptr_o) == ptr, {tag, " R6 pointer"}, rr_ptr_o, ptr);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [15:0] p;
        int p0;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(start_o == 0 && busy_o == 0, "R1 start/busy", {start_o, busy_o}, 0);
        chk(pending_o == 0 && overflow_o == 0, "R1 flags", pending_o | overflow_o, 0);
        chk(rr_ptr_o == 4'd15, "R1 pointer", rr_ptr_o, 15);

        // R2 timing and R9 clear/retrigger
        cutoff = 0; sel_flat = '1; set_sel(5, 0); lat = 3; gcnt = 0;
        pulse(8'h01);
        chk(pending_o[5] == 1, "R2 pending set", pending_o[5], 1);
        @(negedge clk);
        chk(start_o == 1 && grant_slot_o == 4'd5, "R2 start slot", grant_slot_o, 5);
        chk(pending_o[5] == 0, "R9 clear at grant", pending_o[5], 0);
        @(negedge clk);
        chk(start_o == 0, "R2 single cycle start", start_o, 0);
        pulse(8'h01);
        wait_idle();
        chk(gcnt == 2 && glog[1] == 5, "R9 retrigger converted", gcnt, 2);

        // R5/R6 high priority waits for boundary, wheel resumes
        cutoff = 4; lat = 8; sel_flat = '1; set_sel(8, 1); set_sel(9, 1); set_sel(2, 2);
        gcnt = 0;
        pulse(8'h02);
        wait_gcnt(1);
        pulse(8'h04);
        wait_gcnt(2);
        @(negedge clk);
        chk(rr_ptr_o == 4'd8, "R6 pointer held on high grant", rr_ptr_o, 8);
        wait_idle();
        chk(glog[0] == 8, "R4 first wheel grant", glog[0], 8);
        chk(glog[1] == 2, "R5 high slot at boundary", glog[1], 2);
        chk(glog[2] == 9, "R6 wheel resumes", glog[2], 9);

        // R8 overflow
        cutoff = 0; lat = 10; sel_flat = '1; set_sel(3, 3); set_sel(0, 4); gcnt = 0;
        pulse(8'h10);
        wait_gcnt(1);
        pulse(8'h08);
        pulse(8'h08);
        chk(pending_o[3] == 1 && overflow_o[3] == 1, "R8 overflow set", overflow_o[3], 1);
        wait_idle();
        chk(gcnt == 2 && glog[1] == 3, "R8 single queue", gcnt, 2);
        chk(overflow_o[3] == 0, "R8 overflow cleared", overflow_o[3], 0);

        // R7 burst
        cutoff = 2; burst_en = 1; burst_size = 4'd2; burst_sel = 3'd6; lat = 2;
        sel_flat = '1; set_sel(10, 4); gcnt = 0;
        p0 = int'(rr_ptr_o);
        pulse(8'h10);
        repeat (6) @(negedge clk);
        chk(pending_o[10] == 0 && gcnt == 0, "R7 own trigger ignored", gcnt, 0);
        pulse(8'h40);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(gcnt == 3, "R7 burst length", gcnt, 3);
        begin
            int ptr, s;
            ptr = p0;
            for (int i = 0; i < 3; i++) begin
                s = exp_next(16'hFFFC, ptr, 2);
                chk(glog[i] == s, "R7 burst slot", glog[i], s);
                ptr = s;
            end
        end
        burst_en = 0;

        // R10 cutoff extremes
        cutoff = 16; lat = 2; sel_flat = '1; set_sel(1, 0); set_sel(7, 0); set_sel(15, 0);
        gcnt = 0; p0 = int'(rr_ptr_o);
        pulse(8'h01);
        wait_idle();
        chk(glog[0] == 1 && glog[1] == 7 && glog[2] == 15, "R10 all high ascending", glog[2], 15);
        chk(int'(rr_ptr_o) == p0, "R10 pointer frozen", rr_ptr_o, p0);
        cutoff = 0; gcnt = 0; p0 = int'(rr_ptr_o);
        pulse(8'h01);
        wait_idle();
        check_order(16'h8082, p0, 0, "R10 all wheel");

        // random batches
        for (int b = 0; b < 40; b++) begin
            logic [7:0] m;
            int cut;
            cut = $urandom_range(0, 16);
            cutoff = 5'(cut);
            lat = $urandom_range(1, 6);
            m = 8'($urandom_range(1, 255));
            p = '0;
            for (int s = 0; s < 16; s++) begin
                int v;
                v = $urandom_range(0, 7);
                set_sel(s, v);
                if (m[v]) p[s] = 1'b1;
            end
            gcnt = 0; p0 = int'(rr_ptr_o);
            pulse(m);
            chk(pending_o == p, "R2 random pending", pending_o, p);
            wait_idle();
            check_order(p, p0, cut, "random");
        end
        report();
    end
endmodule